// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit effective address for a small microcontroller core with a 16-bit address space. It receives a decoded addressing mode, a base-register select, an accumulator select and a 16-bit operand field. It also receives the current X, Y, SP and PC index values and the A, B and D accumulators. From these it produces the address for the memory access. For the auto-modify modes it also produces the new value of the index register, with a write-back enable and a register select, so that the register file can update X, Y or SP.

The block is one pipeline stage. A request presented with `req_valid_i` high on a rising clock edge produces its results on the registered outputs after that edge. The block supports these modes: page-zero direct, 16-bit extended, PC-relative with an 8- or 16-bit offset, signed 5-bit and 9-bit constant-offset indexed, pre/post increment/decrement with a step of 1 to 8, and accumulator-offset indexed. Instruction fetch, postbyte decoding, the bus and the ALU sit outside the block.

Top module: `ea_addr_unit`

## Requirements
- R1: Every output is zero while `rst_n` is low. The outputs change only on a rising clock edge, one cycle after the request. When `req_valid_i` was low, every output is zero in the following cycle.
- R2: Mode code 0 (direct) gives `ea_o = {8'h00, opnd_i[7:0]}`. The upper operand byte is ignored.
- R3: Mode code 1 (extended) gives `ea_o = opnd_i`.
- R4: Mode code 2 gives PC plus the sign-extended `opnd_i[7:0]`. Mode code 3 gives PC plus `opnd_i`. Both ignore `base_sel_i`.
- R5: Mode code 4 gives base plus the sign-extended `opnd_i[4:0]`. The base select is coded 0=X, 1=Y, 2=SP, 3=PC.
- R6: Mode code 5 gives base plus the sign-extended `opnd_i[8:0]`, using the same base coding as R5.
- R7: The auto-modify step is `opnd_i[2:0]`. The values 1..7 mean themselves and 0 means 8.
- R8: Mode codes 6 (pre-decrement) and 7 (pre-increment) with base X, Y or SP give an address equal to the stepped base. They raise `wb_en_o`, set `wb_sel_o` to the base select, and set `wb_val_o` to that stepped value.
- R9: Mode codes 8 (post-decrement) and 9 (post-increment) with base X, Y or SP give the unmodified base as the address. They raise `wb_en_o` and set `wb_val_o` to the stepped base.
- R10: An auto-modify mode with base select 3 (PC), or a mode code from 11 to 15, gives `ea_o = 0` and no write-back. `ea_valid_o` is still raised.
- R11: Mode code 10 adds an accumulator to the base. `acc_sel_i` is coded 0=A and 1=B (both zero-extended), and 2 or 3=D.
- R12: All sums wrap modulo 2^16. When `wb_en_o` is low, `wb_sel_o` and `wb_val_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| base_sel_i | input | 2 | Base register select (X, Y, SP, PC) |
| acc_sel_i | input | 2 | Accumulator select (A, B, D) |
| opnd_i | input | 16 | Operand, offset or step field |
| x_i | input | 16 | X index value |
| y_i | input | 16 | Y index value |
| sp_i | input | 16 | Stack pointer value |
| pc_i | input | 16 | Program counter value |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| acc_d_i | input | 16 | Accumulator D |
| ea_valid_o | output | 1 | Result valid |
| ea_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Index write-back enable |
| wb_sel_o | output | 2 | Index register to update |
| wb_val_o | output | 16 | New index register value |

## Verification
Directed cases place sign bits exactly at the field edges, such as offset 0x10 in the 5-bit field and 0x100 in the 9-bit field. These show whether each offset width is sign-extended at the correct bit. Other directed cases take X near 0xFFFF and SP near zero with every step code including 0. These separate pre from post ordering, increment from decrement, and the step-8 encoding, and they show wrap-around. Cases with junk in the unused operand bits, PC as an auto-modify base and reserved mode codes show whether ignored fields leak into the address or the write-back. A long run of random requests with gaps in the valid strobe then mixes all modes, base selects and accumulators. A reference model checks every cycle of that run, so a swapped base or accumulator select shows up at once.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned EA_W    = 16;
  localparam int unsigned ACC8_W  = 8;
  localparam int unsigned STEP_W  = 3;
  localparam int unsigned OFS5_W  = 5;
  localparam int unsigned OFS9_W  = 9;
  localparam int unsigned REL8_W  = 8;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned SEL_W   = 2;

  typedef logic [EA_W-1:0] addr_t;

  typedef enum logic [MODE_W-1:0] {
    EAM_DIR     = 4'd0,
    EAM_EXT     = 4'd1,
    EAM_REL8    = 4'd2,
    EAM_REL16   = 4'd3,
    EAM_OFS5    = 4'd4,
    EAM_OFS9    = 4'd5,
    EAM_PREDEC  = 4'd6,
    EAM_PREINC  = 4'd7,
    EAM_POSTDEC = 4'd8,
    EAM_POSTINC = 4'd9,
    EAM_ACC     = 4'd10
  } ea_mode_e;

  typedef enum logic [SEL_W-1:0] {
    BSEL_X  = 2'd0,
    BSEL_Y  = 2'd1,
    BSEL_SP = 2'd2,
    BSEL_PC = 2'd3
  } base_sel_e;

  typedef enum logic [1:0] {
    BK_ZERO = 2'd0,
    BK_PC   = 2'd1,
    BK_SEL  = 2'd2
  } base_kind_e;

  // Sign-extend the low w bits of raw to a full address.
  function automatic addr_t sext_n(input addr_t raw, input int unsigned w);
    addr_t hi_mask;
    hi_mask = ~addr_t'(0) << w;
    return raw[w-1] ? (raw | hi_mask) : (raw & ~hi_mask);
  endfunction

  // Step field: 1..7 as written, 0 stands for 8 (R7).
  function automatic addr_t step_decode(input logic [STEP_W-1:0] s);
    return (s == '0) ? addr_t'(1 << STEP_W) : addr_t'(s);
  endfunction

  function automatic logic is_automod(input logic [MODE_W-1:0] m);
    return (m >= MODE_W'(EAM_PREDEC)) && (m <= MODE_W'(EAM_POSTINC));
  endfunction

  function automatic logic is_premod(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(EAM_PREDEC)) || (m == MODE_W'(EAM_PREINC));
  endfunction

  function automatic logic is_decmod(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(EAM_PREDEC)) || (m == MODE_W'(EAM_POSTDEC));
  endfunction

  function automatic logic is_reserved(input logic [MODE_W-1:0] m);
    return m > MODE_W'(EAM_ACC);
  endfunction
endpackage

// File: rtl/ea_base_mux.sv
module ea_base_mux
  import ea_pkg::*;
#(
  parameter int unsigned W     = EA_W,
  parameter int unsigned NREG  = 4,
  localparam int unsigned SW   = $clog2(NREG)
) (
  input  logic [W-1:0]  x_i,
  input  logic [W-1:0]  y_i,
  input  logic [W-1:0]  sp_i,
  input  logic [W-1:0]  pc_i,
  input  logic [SW-1:0] sel_i,
  output logic [W-1:0]  base_o
);
  logic [W-1:0] bank [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_bank
      if (g == 0)      begin : g_x  assign bank[g] = x_i;  end
      else if (g == 1) begin : g_y  assign bank[g] = y_i;  end
      else if (g == 2) begin : g_sp assign bank[g] = sp_i; end
      else             begin : g_pc assign bank[g] = pc_i; end
    end
  endgenerate

  assign base_o = bank[sel_i];
endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
  import ea_pkg::*;
#(
  parameter int unsigned W = EA_W,
  parameter int unsigned AW8 = ACC8_W
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic [W-1:0]      opnd_i,
  input  logic [AW8-1:0]    acc_a_i,
  input  logic [AW8-1:0]    acc_b_i,
  input  logic [W-1:0]      acc_d_i,
  output logic [W-1:0]      offset_o,
  output base_kind_e        kind_o
);
  logic [W-1:0] acc_pick;

  always_comb begin
    unique case (acc_sel_i)
      2'd0:    acc_pick = W'(acc_a_i);
      2'd1:    acc_pick = W'(acc_b_i);
      default: acc_pick = acc_d_i;
    endcase
  end

  always_comb begin
    offset_o = '0;
    kind_o   = BK_ZERO;
    unique case (mode_i)
      MODE_W'(EAM_DIR):   begin offset_o = {{(W-8){1'b0}}, opnd_i[7:0]};       kind_o = BK_ZERO; end
      MODE_W'(EAM_EXT):   begin offset_o = opnd_i;                              kind_o = BK_ZERO; end
      MODE_W'(EAM_REL8):  begin offset_o = sext_n(opnd_i, REL8_W);              kind_o = BK_PC;   end
      MODE_W'(EAM_REL16): begin offset_o = opnd_i;                              kind_o = BK_PC;   end
      MODE_W'(EAM_OFS5):  begin offset_o = sext_n(opnd_i, OFS5_W);              kind_o = BK_SEL;  end
      MODE_W'(EAM_OFS9):  begin offset_o = sext_n(opnd_i, OFS9_W);              kind_o = BK_SEL;  end
      MODE_W'(EAM_ACC):   begin offset_o = acc_pick;                            kind_o = BK_SEL;  end
      default:            begin offset_o = '0;                                  kind_o = BK_ZERO; end
    endcase
  end
endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg
  import ea_pkg::*;
#(
  parameter int unsigned W = EA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [W-1:0]     d_ea,
  input  logic             d_wb_en,
  input  logic [SEL_W-1:0] d_wb_sel,
  input  logic [W-1:0]     d_wb_val,
  output logic             q_valid,
  output logic [W-1:0]     q_ea,
  output logic             q_wb_en,
  output logic [SEL_W-1:0] q_wb_sel,
  output logic [W-1:0]     q_wb_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_ea     <= '0;
      q_wb_en  <= 1'b0;
      q_wb_sel <= '0;
      q_wb_val <= '0;
    end else begin
      q_valid  <= d_valid;
      q_ea     <= d_ea;
      q_wb_en  <= d_wb_en;
      q_wb_sel <= d_wb_sel;
      q_wb_val <= d_wb_val;
    end
  end
endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit
  import ea_pkg::*;
#(
  parameter int unsigned W = EA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [3:0]        mode_i,
  input  logic [1:0]        base_sel_i,
  input  logic [1:0]        acc_sel_i,
  input  logic [15:0]       opnd_i,
  input  logic [15:0]       x_i,
  input  logic [15:0]       y_i,
  input  logic [15:0]       sp_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        acc_a_i,
  input  logic [7:0]        acc_b_i,
  input  logic [15:0]       acc_d_i,
  output logic              ea_valid_o,
  output logic [15:0]       ea_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_sel_o,
  output logic [15:0]       wb_val_o
);
  logic [W-1:0] sel_base;
  logic [W-1:0] offset;
  base_kind_e   kind;
  logic [W-1:0] eff_base;
  logic [W-1:0] plain_sum;
  logic [W-1:0] step;
  logic [W-1:0] stepped;

  // Named events, observed by the bound checker.
  logic ev_automod;
  logic ev_illegal;
  logic ev_wb_fire;

  logic [W-1:0]     nxt_ea;
  logic [W-1:0]     nxt_wb_val;
  logic [SEL_W-1:0] nxt_wb_sel;

  ea_base_mux #(.W(W), .NREG(4)) u_base (
    .x_i   (x_i),
    .y_i   (y_i),
    .sp_i  (sp_i),
    .pc_i  (pc_i),
    .sel_i (base_sel_i),
    .base_o(sel_base)
  );

  ea_offset_gen #(.W(W), .AW8(ACC8_W)) u_ofs (
    .mode_i   (mode_i),
    .acc_sel_i(acc_sel_i),
    .opnd_i   (opnd_i),
    .acc_a_i  (acc_a_i),
    .acc_b_i  (acc_b_i),
    .acc_d_i  (acc_d_i),
    .offset_o (offset),
    .kind_o   (kind)
  );

  always_comb begin
    unique case (kind)
      BK_PC:   eff_base = pc_i;
      BK_SEL:  eff_base = sel_base;
      default: eff_base = '0;
    endcase
  end

  // Sums wrap modulo 2^W (R12).
  assign plain_sum = eff_base + offset;
  assign step      = step_decode(opnd_i[STEP_W-1:0]);
  assign stepped   = is_decmod(mode_i) ? (sel_base - step) : (sel_base + step);

  assign ev_automod = is_automod(mode_i);
  assign ev_illegal = is_reserved(mode_i) ||
                      (ev_automod && (base_sel_i == SEL_W'(BSEL_PC)));
  assign ev_wb_fire = req_valid_i && ev_automod && !ev_illegal;

  always_comb begin
    nxt_ea     = '0;
    nxt_wb_val = '0;
    nxt_wb_sel = '0;
    if (req_valid_i && !ev_illegal) begin
      if (ev_automod) begin
        nxt_ea     = is_premod(mode_i) ? stepped : sel_base;
        nxt_wb_val = stepped;
        nxt_wb_sel = base_sel_i;
      end else begin
        nxt_ea = plain_sum;
      end
    end
  end

  ea_out_reg #(.W(W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (req_valid_i),
    .d_ea    (nxt_ea),
    .d_wb_en (ev_wb_fire),
    .d_wb_sel(nxt_wb_sel),
    .d_wb_val(nxt_wb_val),
    .q_valid (ea_valid_o),
    .q_ea    (ea_o),
    .q_wb_en (wb_en_o),
    .q_wb_sel(wb_sel_o),
    .q_wb_val(wb_val_o)
  );
endmodule

// File: rtl/ea_addr_chk.sv
module ea_addr_chk
  import ea_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic [3:0]  mode_i,
  input logic [1:0]  base_sel_i,
  input logic [15:0] opnd_i,
  input logic        ev_illegal,
  input logic        ea_valid_o,
  input logic [15:0] ea_o,
  input logic        wb_en_o,
  input logic [1:0]  wb_sel_o,
  input logic [15:0] wb_val_o
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> ea_valid_o);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!ea_valid_o && ea_o == '0 && !wb_en_o));

  assert_direct_page0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i == 4'd0) |=> (ea_o[15:8] == 8'h00));

  assert_extended_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i == 4'd1) |=> (ea_o == $past(opnd_i)));

  assert_pre_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (mode_i == 4'd6 || mode_i == 4'd7) && base_sel_i != 2'd3)
      |=> (wb_en_o && ea_o == wb_val_o && wb_sel_o == $past(base_sel_i)));

  assert_post_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i == 4'd9 && base_sel_i != 2'd3)
      |=> (wb_en_o && wb_val_o == ea_o + step_decode($past(opnd_i[2:0]))));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && ev_illegal) |=> (!wb_en_o && ea_o == '0 && ea_valid_o));

  assert_wb_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_en_o |-> (wb_val_o == '0 && wb_sel_o == '0));

  assert_wb_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (ea_valid_o && wb_sel_o != 2'd3));
endmodule

bind ea_addr_unit ea_addr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .mode_i     (mode_i),
  .base_sel_i (base_sel_i),
  .opnd_i     (opnd_i),
  .ev_illegal (ev_illegal),
  .ea_valid_o (ea_valid_o),
  .ea_o       (ea_o),
  .wb_en_o    (wb_en_o),
  .wb_sel_o   (wb_sel_o),
  .wb_val_o   (wb_val_o)
);

// File: tb/tb_ea_addr_unit.sv
`timescale 1ns/1ps
module tb_ea_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  base_sel_i = '0;
  logic [1:0]  acc_sel_i = '0;
  logic [15:0] opnd_i = '0;
  logic [15:0] x_i = '0, y_i = '0, sp_i = '0, pc_i = '0, acc_d_i = '0;
  logic [7:0]  acc_a_i = '0, acc_b_i = '0;
  logic        ea_valid_o, wb_en_o;
  logic [15:0] ea_o, wb_val_o;
  logic [1:0]  wb_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int    v, ea, wbe, wbs, wbv;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  ea_addr_unit dut (.*);

  function automatic int sx(input int val, input int w);
    return (val >= (1 << (w - 1))) ? val - (1 << w) : val;
  endfunction

  // Behavioural reference built from the requirements.
  function automatic exp_t model(input int v, m, bs, as, op, x, y, sp, pc, a, b, d, input string tag);
    exp_t e;
    int base, st, nb;
    e.v = v; e.ea = 0; e.wbe = 0; e.wbs = 0; e.wbv = 0; e.tag = tag;
    if (v == 0) return e;
    base = (bs == 0) ? x : (bs == 1) ? y : (bs == 2) ? sp : pc;
    case (m)
      0: e.ea = op % 256;
      1: e.ea = op;
      2: e.ea = pc + sx(op % 256, 8);
      3: e.ea = pc + op;
      4: e.ea = base + sx(op % 32, 5);
      5: e.ea = base + sx(op % 512, 9);
      6, 7, 8, 9: if (bs != 3) begin
        st = (op % 8 == 0) ? 8 : op % 8;
        nb = (m == 6 || m == 8) ? base - st : base + st;
        e.ea  = (m <= 7) ? nb : base;
        e.wbe = 1; e.wbs = bs; e.wbv = nb & 16'hFFFF;
      end
      10: e.ea = base + ((as == 0) ? a : (as == 1) ? b : d);
      default: e.ea = 0;
    endcase
    e.ea = e.ea & 16'hFFFF;
    return e;
  endfunction

  function automatic string mode_tag(input int m, input int bs, input int v);
    if (v == 0) return "R1";
    case (m)
      0: return "R2";  1: return "R3";  2, 3: return "R4";
      4: return "R5";  5: return "R6";  10: return "R11";
      6, 7: return (bs == 3) ? "R10" : "R8";
      8, 9: return (bs == 3) ? "R10" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (int'(ea_valid_o) != e.v || int'(ea_o) != e.ea || int'(wb_en_o) != e.wbe ||
        int'(wb_sel_o) != e.wbs || int'(wb_val_o) != e.wbv) begin
      fails++;
      $display("FAIL %s: got v=%0d ea=%h wbe=%0d wbs=%0d wbv=%h exp v=%0d ea=%h wbe=%0d wbs=%0d wbv=%h",
               e.tag, ea_valid_o, ea_o, wb_en_o, wb_sel_o, wb_val_o,
               e.v, e.ea[15:0], e.wbe, e.wbs, e.wbv[15:0]);
    end
  endtask

  // Runs at the falling edge: check the previous request's result, then drive the next.
  task automatic step_req(input int v, m, bs, as, op, x, y, sp, pc, a, b, d, input string tag_in);
    string tag;
    @(negedge clk);
    if (expq.size() > 0) compare(expq.pop_front());
    tag = (tag_in == "") ? mode_tag(m, bs, v) : tag_in;
    req_valid_i = v[0]; mode_i = m[3:0]; base_sel_i = bs[1:0]; acc_sel_i = as[1:0];
    opnd_i = op[15:0]; x_i = x[15:0]; y_i = y[15:0]; sp_i = sp[15:0]; pc_i = pc[15:0];
    acc_a_i = a[7:0]; acc_b_i = b[7:0]; acc_d_i = d[15:0];
    expq.push_back(model(v, m, bs, as, op, x, y, sp, pc, a, b, d, tag));
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t z;
    z = model(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // Reset state, with a live request on the inputs (R1).
    req_valid_i = 1'b1; mode_i = 4'd1; opnd_i = 16'hBEEF;
    repeat (3) begin @(negedge clk); compare(z); end
    rst_n = 1'b1;
    req_valid_i = 1'b0;
    // R2: upper byte junk ignored
    step_req(1, 0, 2, 0, 'hA5C3, 'h1111, 0, 0, 0, 0, 0, 0, "R2");
    step_req(1, 1, 0, 0, 'hFFFE, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R4: negative 8-bit, and 16-bit with wrap
    step_req(1, 2, 1, 0, 'h1280, 0, 'h7777, 0, 'h0100, 0, 0, 0, "R4");
    step_req(1, 3, 0, 0, 'hF000, 0, 0, 0, 'h2345, 0, 0, 0, "R4");
    // R5: 0x10 is -16, bits above the field ignored
    step_req(1, 4, 0, 0, 'hFFF0, 'h0008, 0, 0, 0, 0, 0, 0, "R5");
    step_req(1, 4, 3, 0, 'h000F, 0, 0, 0, 'h4000, 0, 0, 0, "R5");
    // R6: 0x100 is -256
    step_req(1, 5, 2, 0, 'h0100, 0, 0, 'h0080, 0, 0, 0, 0, "R6");
    step_req(1, 5, 1, 0, 'h00FF, 0, 'h1000, 0, 0, 0, 0, 0, "R6");
    // R7: step code 0 is 8 in each auto-modify mode
    for (int m = 6; m <= 9; m++) step_req(1, m, 0, 0, 'hFFF8, 'h0100, 0, 0, 0, 0, 0, 0, "R7");
    // R8 / R9 with wrap (R12)
    step_req(1, 7, 0, 0, 3, 'hFFFE, 0, 0, 0, 0, 0, 0, "R12");
    step_req(1, 8, 2, 0, 5, 0, 0, 'h0002, 0, 0, 0, 0, "R12");
    step_req(1, 6, 1, 0, 1, 0, 'h0040, 0, 0, 0, 0, 0, "R8");
    step_req(1, 9, 2, 0, 7, 0, 0, 'h0200, 0, 0, 0, 0, "R9");
    // R10: PC base on auto-modify, reserved modes
    step_req(1, 7, 3, 0, 2, 'h10, 'h20, 'h30, 'h4000, 0, 0, 0, "R10");
    step_req(1, 12, 0, 0, 'h1234, 'h10, 0, 0, 0, 0, 0, 0, "R10");
    step_req(1, 15, 1, 2, 'h1234, 0, 'h10, 0, 0, 0, 0, 0, "R10");
    // R11: A, B zero-extended, D with wrap, code 3 also D
    step_req(1, 10, 0, 0, 0, 'h1000, 0, 0, 0, 'hFF, 'h01, 'h0002, "R11");
    step_req(1, 10, 3, 1, 0, 0, 0, 0, 'h2000, 'h01, 'h80, 'h0002, "R11");
    step_req(1, 10, 1, 2, 0, 0, 'hF000, 0, 0, 'h01, 'h02, 'h2000, "R11");
    step_req(1, 10, 2, 3, 0, 0, 0, 'h0010, 0, 0, 0, 'hFFF0, "R11");
    // R1: idle request after an auto-modify clears everything
    step_req(1, 9, 0, 0, 4, 'h0100, 0, 0, 0, 0, 0, 0, "R9");
    step_req(0, 9, 0, 0, 4, 'h0100, 0, 0, 0, 0, 0, 0, "R1");
    // Random mix
    for (int i = 0; i < 3000; i++)
      step_req(($urandom % 5) != 0, $urandom % 16, $urandom % 4, $urandom % 4,
               $urandom % 65536, $urandom % 65536, $urandom % 65536, $urandom % 65536,
               $urandom % 65536, $urandom % 256, $urandom % 256, $urandom % 65536, "");
    step_req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    if (expq.size() > 0) compare(expq.pop_front());
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule